// File: doc/BRIEF.md
# Byte-Addressed Two-Wire Memory Target

This block is an I2C target that sits in front of a 256-location, 8-bit storage array. It watches oversampled SCL and SDA and answers only a control byte whose upper bits carry a fixed device-type code and whose next three bits equal the three strap inputs. Its only output is an open-drain enable that pulls SDA low.

One word pointer is kept between transactions. A write transaction carries a word address and one data byte. It stores the byte and leaves the pointer just past it. A read begins at the current pointer, so the master picks the read style through bus sequencing alone. It can read at the pointer directly. It can load the pointer with a write that is cut short by a repeated start. It can also keep acknowledging bytes, which streams the array in address order and wraps inside the 256 locations.

Each system-clock sample of SCL and SDA goes through a short synchronizer. Start and stop are recognised as SDA edges while SCL is high. The system clock must run at least eight times faster than SCL.

Top module: `i2c_mem_target`

## Requirements
- R1: The control byte is received MSB first as type code 1010, then strap bits 2, 1 and 0, then the direction bit (1 = read). When the code and straps match, the target pulls SDA low for the ninth clock.
- R2: When the type code or the strap bits do not match, the target leaves SDA released and ignores all following bits until the next start, so no memory location changes.
- R3: A write (direction 0) acknowledges the word-address byte and one data byte, stores the data at that address, and leaves the pointer at address + 1.
- R4: The pointer is 8 bits and wraps from 255 to 0, both after a write to location 255 and while streaming reads.
- R5: A read that follows the control byte directly returns the byte at the current pointer, and the pointer then advances by one, so consecutive reads return n, n+1.
- R6: A write that carries only a word address and is then followed by a repeated start loads the pointer and changes no stored byte. A read control byte after it returns the byte at that address.
- R7: When the master acknowledges a read byte, the target sends the byte at the next address in the same transaction, and it wraps from 255 to 0.
- R8: When the master answers a read byte with NACK, the target leaves SDA released in that slot and afterwards, and a stop returns it to idle.
- R9: The target changes its SDA drive only while SCL is low, except when a start or stop forces a release.
- R10: In a write, a second data byte after the first is not acknowledged and is not stored.
- R11: After reset, SDA is released and the pointer is 0. Reset does not change the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock level |
| sda_i | input | 1 | Sampled bus data level |
| strap_i | input | 3 | Device-select straps compared with control-byte bits 3..1 |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A wrong pointer shows up on the very next read as a wrong data byte. Because every location holds a different value, an off-by-one or a wrap error cannot hide. A state machine that has lost track shows up within one byte: an acknowledge is missing or appears where none should be, or the slave still drives SDA during the master's acknowledge slot. Drive changes while SCL is high are watched on every cycle. A wrong write path shows up when a location that should be untouched is read back.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int          BYTE_W   = 8;
    localparam int          ADDR_W   = 8;
    localparam int          CNT_W    = $clog2(BYTE_W) + 1;
    localparam logic [3:0]  DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } eng_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic ctrl_hit(input logic [BYTE_W-1:0] b,
                                      input logic [2:0] strap);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == strap);
    endfunction

endpackage

// File: rtl/i2cm_bus_sense.sv
module i2cm_bus_sense
    import i2cm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_sy;
    logic [STAGES-1:0] sda_sy;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy <= '1;
            sda_sy <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[STAGES-2:0], scl_i};
            sda_sy <= {sda_sy[STAGES-2:0], sda_i};
            scl_d  <= scl_sy[STAGES-1];
            sda_d  <= sda_sy[STAGES-1];
        end
    end

    assign scl_now = scl_sy[STAGES-1];
    assign sda_now = sda_sy[STAGES-1];

    always_comb begin
        ev.scl      = scl_now;
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_d;
        ev.scl_fall = ~scl_now & scl_d;
        ev.start    = scl_now & scl_d & sda_d & ~sda_now;
        ev.stop     = scl_now & scl_d & ~sda_d & sda_now;
    end

endmodule

// File: rtl/i2cm_store.sv
module i2cm_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        strap,
    input  logic [BYTE_W-1:0] rdata,
    output logic              we,
    output logic [ADDR_W-1:0] ptr,
    output logic [BYTE_W-1:0] wdata,
    output logic              sda_oe
);
    eng_state_t        st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic              rw;
    logic              mack;
    logic              byte_in;
    logic              rx_state;

    assign rx_state = (st == ST_CTRL) || (st == ST_WADDR) || (st == ST_WDATA);
    assign byte_in  = rx_state && ev.scl_fall && (cnt == CNT_W'(BYTE_W));
    assign we       = byte_in && (st == ST_WDATA);
    assign wdata    = sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            tx     <= '0;
            rw     <= 1'b0;
            mack   <= 1'b0;
            ptr    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            st     <= ST_CTRL;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_CTRL, ST_WADDR, ST_WDATA: begin
                    if (ev.scl_rise && (cnt < CNT_W'(BYTE_W))) begin
                        sh  <= {sh[BYTE_W-2:0], ev.sda};
                        cnt <= cnt + 1'b1;
                    end else if (byte_in) begin
                        cnt <= '0;
                        if (st == ST_CTRL) begin
                            if (ctrl_hit(sh, strap)) begin
                                rw     <= sh[0];
                                sda_oe <= 1'b1;
                                st     <= ST_CTRL_ACK;
                            end else begin
                                st     <= ST_IDLE;
                            end
                        end else if (st == ST_WADDR) begin
                            ptr    <= sh[ADDR_W-1:0];
                            sda_oe <= 1'b1;
                            st     <= ST_WADDR_ACK;
                        end else begin
                            ptr    <= ptr + 1'b1;
                            sda_oe <= 1'b1;
                            st     <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_CTRL_ACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            tx     <= rdata;
                            sda_oe <= ~rdata[BYTE_W-1];
                            st     <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_WADDR;
                        end
                    end
                end
                ST_WADDR_ACK: begin
                    if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        st     <= ST_WDATA;
                    end
                end
                ST_WDATA_ACK: begin
                    if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        st     <= ST_IDLE;
                    end
                end
                ST_RDATA: begin
                    if (ev.scl_fall) begin
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                            st     <= ST_RACK;
                        end else begin
                            cnt    <= cnt + 1'b1;
                            tx     <= {tx[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        mack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        cnt <= '0;
                        if (mack) begin
                            tx     <= rdata;
                            sda_oe <= ~rdata[BYTE_W-1];
                            st     <= ST_RDATA;
                        end else begin
                            st     <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_start_enters_ctrl_R1: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !ev.stop) |=> (st == ST_CTRL));

    assert_foreign_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CTRL && byte_in && !ctrl_hit(sh, strap) && !ev.start && !ev.stop)
        |=> (st == ST_IDLE && !sda_oe));

    assert_write_steps_ptr_R3: assert property (@(posedge clk) disable iff (rst)
        (we && !ev.start && !ev.stop) |=> (ptr == $past(ptr) + 1'b1));

    assert_read_steps_ptr_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RDATA && ev.scl_fall && cnt == CNT_W'(BYTE_W - 1) && !ev.start && !ev.stop)
        |=> (ptr == $past(ptr) + 1'b1 && st == ST_RACK));

    assert_stop_releases_R8: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);

    assert_drive_moves_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(ev.start) && !$past(ev.stop) && !$past(rst)) |-> !ev.scl);

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2cm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);
    bus_ev_t           ev;
    logic              we;
    logic [ADDR_W-1:0] ptr;
    logic [BYTE_W-1:0] wdata;
    logic [BYTE_W-1:0] rdata;

    i2cm_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cm_engine u_engine (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .strap  (strap_i),
        .rdata  (rdata),
        .we     (we),
        .ptr    (ptr),
        .wdata  (wdata),
        .sda_oe (sda_oe_o)
    );

    i2cm_store #(.AW(ADDR_W), .DW(BYTE_W)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (ptr),
        .wdata (wdata),
        .raddr (ptr),
        .rdata (rdata)
    );

endmodule

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_oe;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int glitches = 0;
    bit done = 0;
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;
    logic [7:0] model [256];

    localparam logic [7:0] CW = 8'hAA;
    localparam logic [7:0] CR = 8'hAB;

    always #4 clk = ~clk;

    i2c_mem_target uut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .sda_oe_o (sda_oe)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 37 + 11);
    endfunction

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R9 monitor: drive must hold while SCL stays high
    always @(negedge clk) begin
        if (!rst && scl && scl_prev && (sda_oe !== oe_prev)) glitches++;
        scl_prev = scl;
        oe_prev  = sda_oe;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 195000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic m, output logic s);
        wait_clk(2); sda_m = m;
        wait_clk(3); scl = 1'b1;
        wait_clk(2); s = sda_line;
        wait_clk(3); scl = 1'b0;
    endtask

    task automatic do_start();
        wait_clk(2); sda_m = 1'b1;
        wait_clk(3); scl = 1'b1;
        wait_clk(3); sda_m = 1'b0;
        wait_clk(3); scl = 1'b0;
    endtask

    task automatic do_stop();
        wait_clk(2); sda_m = 1'b0;
        wait_clk(3); scl = 1'b1;
        wait_clk(3); sda_m = 1'b1;
        wait_clk(3);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] d, output logic slot);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(~master_ack, slot);
    endtask

    task automatic write_one(input logic [7:0] a, input logic [7:0] d);
        logic ack;
        do_start();
        send_byte(CW, ack);  chk("R1 ctrl ack", ack, 1);
        send_byte(a, ack);   chk("R3 addr ack", ack, 1);
        send_byte(d, ack);   chk("R3 data ack", ack, 1);
        do_stop();
        model[a] = d;
    endtask

    task automatic set_ptr(input logic [7:0] a);
        logic ack;
        do_start();
        send_byte(CW, ack);  chk("R6 ctrl ack", ack, 1);
        send_byte(a, ack);   chk("R6 addr ack", ack, 1);
    endtask

    task automatic read_one(input string tag, input logic [7:0] exp);
        logic ack;
        logic slot;
        logic [7:0] d;
        do_start();
        send_byte(CR, ack);       chk("R1 read ctrl ack", ack, 1);
        recv_byte(1'b0, d, slot);
        chk(tag, d, exp);
        chk("R8 nack slot released", slot, 1);
        do_stop();
        wait_clk(2);
        chk("R8 released after stop", sda_oe, 0);
    endtask

    initial begin
        logic ack;
        logic slot;
        logic [7:0] d;
        int p;

        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        chk("R11 oe after reset", sda_oe, 0);

        // R3, R4: fill every location, pointer wraps to 0 after 255
        for (int a = 0; a < 256; a++) write_one(8'(a), pat(a));
        read_one("R4 wrap after write 255", model[0]);
        read_one("R5 current read n+1", model[1]);

        // R6 random reads, then R5 current reads after them
        for (int k = 0; k < 6; k++) begin
            p = (k * 53 + 128) % 256;
            set_ptr(8'(p));
            read_one("R6 random read", model[p]);
            read_one("R5 follow-on read", model[(p + 1) % 256]);
        end

        // R7 sequential read of the whole array plus wrap
        set_ptr(8'h00);
        do_start();
        send_byte(CR, ack); chk("R7 ctrl ack", ack, 1);
        for (int i = 0; i < 258; i++) begin
            recv_byte(i != 257, d, slot);
            chk("R7 sequential byte", d, model[i % 256]);
        end
        chk("R8 final nack slot", slot, 1);
        do_stop();
        read_one("R7 pointer after stream", model[2]);

        // R2 foreign strap and foreign type code
        do_start();
        send_byte({4'hA, 3'b100, 1'b0}, ack); chk("R2 strap mismatch nack", ack, 0);
        send_byte(8'h05, ack);                chk("R2 ignored addr", ack, 0);
        send_byte(8'h00, ack);                chk("R2 ignored data", ack, 0);
        do_stop();
        do_start();
        send_byte({4'hB, 3'b101, 1'b0}, ack); chk("R2 type mismatch nack", ack, 0);
        send_byte(8'h05, ack);                chk("R2 ignored addr", ack, 0);
        send_byte(8'hFF, ack);                chk("R2 ignored data", ack, 0);
        do_stop();
        set_ptr(8'h05);
        read_one("R2 location untouched", model[5]);

        // R10 second data byte refused
        do_start();
        send_byte(CW, ack);    chk("R10 ctrl ack", ack, 1);
        send_byte(8'd10, ack); chk("R10 addr ack", ack, 1);
        send_byte(8'h3C, ack); chk("R10 first data ack", ack, 1);
        send_byte(8'h99, ack); chk("R10 second data nack", ack, 0);
        do_stop();
        model[10] = 8'h3C;
        read_one("R3 pointer after write", model[11]);
        set_ptr(8'd10);
        read_one("R10 stored first byte", 8'h3C);

        // R4 write at top then current read wraps
        write_one(8'hFF, 8'h5A);
        read_one("R4 read after write 255", model[0]);

        // R11 reset in mid-run keeps data, clears pointer
        write_one(8'h40, 8'h77);
        wait_clk(2); rst = 1'b1; wait_clk(3); rst = 1'b0; wait_clk(3);
        chk("R11 oe after second reset", sda_oe, 0);
        read_one("R11 pointer zero after reset", model[0]);

        chk("R9 no drive change with SCL high", glitches, 0);
        report();
    end

endmodule